// File: doc/BRIEF.md
# Per-Channel Link Fault Status Combiner

This block produces one link-good indication for each lane of a multi-lane serial receiver. Each lane supplies a set of digital status inputs, one value per recovered bit time: a strobe that marks a data transition on that bit, an analog signal-present flag, a flag that is high while the frequency range controller forces the lane's clock onto the reference, a lane enable, and a local loopback select. A two-bit amplitude threshold code is shared by all lanes.

Inside the block, each lane has a saturating counter that measures how long the line has gone without a transition. The block then gates every fault source according to the lane's mode. Loopback removes the analog flag. The threshold code `00` also removes the analog flag. A disabled lane reports a fault regardless of its other inputs. The combined result is registered and driven out active low, so a high output means the link is good. Downstream logic can use it, for example, to switch to a redundant input.

Top module: `link_fault_top`

## Requirements
- R1: There are `NUM_CH` lanes (default 4). Each lane's output depends only on that lane's inputs and on the shared threshold code and reset.
- R2: `faultN[i]` is active low. It is registered, so on the clock edge that samples a bit it takes the status that includes that bit. It is 1 only when no enabled fault source is present.
- R3: A lane whose last `RUN_LIMIT` (default 60) bits had no transition, counted since its last transition, reset or disable, still reads good. On the next bit without a transition it reads fault.
- R4: The no-transition count saturates and does not wrap, so the fault holds however long the line stays idle. The first bit with `transition[i]=1` clears the fault on the same edge.
- R5: When `ampSel` is `2'b00`, `sigDetect` has no effect. For codes `2'b01`, `2'b10` and `2'b11`, `sigDetect[i]=0` makes the lane fault.
- R6: When `loopback[i]=1`, `sigDetect[i]` has no effect. Forcing and the no-transition count still raise the fault.
- R7: When `chanEn[i]=0`, `faultN[i]` is 0 whatever the other inputs are, and the lane's no-transition count restarts from zero.
- R8: While `forcing[i]=1`, `faultN[i]` is 0.
- R9: Reset is synchronous and active high. While it is high, every `faultN` bit is 0 and every count is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock; one edge per received bit |
| rst | input | 1 | Synchronous active-high reset |
| ampSel | input | 2 | Shared analog threshold code; 00 switches the analog flag off |
| chanEn | input | NUM_CH | Per-lane enable |
| loopback | input | NUM_CH | Per-lane local loopback select |
| forcing | input | NUM_CH | Per-lane range-controller forcing flag |
| sigDetect | input | NUM_CH | Per-lane analog signal-present flag |
| transition | input | NUM_CH | Per-lane strobe, 1 when the current bit has a transition |
| faultN | output | NUM_CH | Per-lane link status, 0 = fault |

## Verification
The bench builds the block with its default parameters: four lanes and a limit of 60 idle bits. With these values every lane can be tested at exactly 60 and 61 idle bits. An idle run longer than 64 bits reaches past the point where a 6-bit counter would wrap, which exposes a missing saturation. Each mask is applied to one lane while the other lanes keep toggling, so any leakage between lanes shows up on their outputs.

// File: rtl/lfc_pkg.sv
package lfc_pkg;
  typedef enum logic [1:0] {
    AMP_OFF  = 2'b00,
    AMP_LOW  = 2'b01,
    AMP_MID  = 2'b10,
    AMP_HIGH = 2'b11
  } ampSel_t;

  // Strobes from control to the run-length datapath, one per lane
  typedef struct packed {
    logic clearRun;
    logic stepRun;
  } runCtl_t;
endpackage

// File: rtl/lfc_datapath.sv
module lfc_datapath
  import lfc_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int RUN_LIMIT = 60
) (
  input  logic                 clk,
  input  logic                 rst,
  input  runCtl_t [NUM_CH-1:0] runCtl,
  output logic    [NUM_CH-1:0] runFault
);
  localparam int CNT_W = $clog2(RUN_LIMIT + 2);
  localparam logic [CNT_W-1:0] SAT_V   = CNT_W'(RUN_LIMIT + 1);
  localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(RUN_LIMIT);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_lane
    logic [CNT_W-1:0] runLen;
    logic [CNT_W-1:0] runNext;

    always_comb begin
      if (runCtl[ch].clearRun)
        runNext = '0;
      else if (runCtl[ch].stepRun && runLen != SAT_V)
        runNext = runLen + CNT_W'(1);
      else
        runNext = runLen;
    end

    always_ff @(posedge clk) runLen <= runNext;

    assign runFault[ch] = runNext > LIMIT_V;

    AST_RUN_BOUNDED: assert property (@(posedge clk) disable iff (rst)
      runLen <= SAT_V); // R4
    AST_SAT_HOLDS: assert property (@(posedge clk) disable iff (rst)
      (runLen == SAT_V && !runCtl[ch].clearRun) |=> runLen == SAT_V); // R4
    AST_CLEAR_ZERO: assert property (@(posedge clk)
      rst |=> runLen == '0); // R9
  end
endmodule

// File: rtl/lfc_ctrl.sv
module lfc_ctrl
  import lfc_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  ampSel_t              ampSel,
  input  logic    [NUM_CH-1:0] chanEn,
  input  logic    [NUM_CH-1:0] loopback,
  input  logic    [NUM_CH-1:0] forcing,
  input  logic    [NUM_CH-1:0] sigDetect,
  input  logic    [NUM_CH-1:0] transition,
  input  logic    [NUM_CH-1:0] runFault,
  output runCtl_t [NUM_CH-1:0] runCtl,
  output logic    [NUM_CH-1:0] faultN
);
  logic ampOff;
  assign ampOff = (ampSel == AMP_OFF);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_lane
    logic sigOk;
    logic goodNext;

    always_comb begin
      runCtl[ch].clearRun = rst | ~chanEn[ch] | transition[ch];
      runCtl[ch].stepRun  = ~runCtl[ch].clearRun;
    end

    assign sigOk    = loopback[ch] | ampOff | sigDetect[ch];
    assign goodNext = chanEn[ch] & ~forcing[ch] & ~runFault[ch] & sigOk;

    always_ff @(posedge clk) begin
      if (rst) faultN[ch] <= 1'b0;
      else     faultN[ch] <= goodNext;
    end

    AST_RESET_FAULTS: assert property (@(posedge clk)
      rst |=> !faultN[ch]); // R9
    AST_DISABLED_FAULTS: assert property (@(posedge clk) disable iff (rst)
      !chanEn[ch] |=> !faultN[ch]); // R7
    AST_FORCE_FAULTS: assert property (@(posedge clk) disable iff (rst)
      forcing[ch] |=> !faultN[ch]); // R8
    AST_LONGRUN_FAULTS: assert property (@(posedge clk) disable iff (rst)
      runFault[ch] |=> !faultN[ch]); // R3
    AST_SIGLOSS_FAULTS: assert property (@(posedge clk) disable iff (rst)
      (!loopback[ch] && !ampOff && !sigDetect[ch]) |=> !faultN[ch]); // R5
  end
endmodule

// File: rtl/link_fault_top.sv
module link_fault_top
  import lfc_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int RUN_LIMIT = 60
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        ampSel,
  input  logic [NUM_CH-1:0] chanEn,
  input  logic [NUM_CH-1:0] loopback,
  input  logic [NUM_CH-1:0] forcing,
  input  logic [NUM_CH-1:0] sigDetect,
  input  logic [NUM_CH-1:0] transition,
  output logic [NUM_CH-1:0] faultN
);
  runCtl_t [NUM_CH-1:0] runCtl;
  logic    [NUM_CH-1:0] runFault;

  lfc_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .ampSel     (ampSel_t'(ampSel)),
    .chanEn     (chanEn),
    .loopback   (loopback),
    .forcing    (forcing),
    .sigDetect  (sigDetect),
    .transition (transition),
    .runFault   (runFault),
    .runCtl     (runCtl),
    .faultN     (faultN)
  );

  lfc_datapath #(.NUM_CH(NUM_CH), .RUN_LIMIT(RUN_LIMIT)) u_data (
    .clk      (clk),
    .rst      (rst),
    .runCtl   (runCtl),
    .runFault (runFault)
  );
endmodule

// File: tb/link_fault_top_tb.sv
module link_fault_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int LIM = 60;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [1:0]     ampSel = 2'b01;
  logic [NCH-1:0] chanEn = '1;
  logic [NCH-1:0] loopback = '0;
  logic [NCH-1:0] forcing = '0;
  logic [NCH-1:0] sigDetect = '1;
  logic [NCH-1:0] transition = '1;
  logic [NCH-1:0] faultN;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  link_fault_top #(.NUM_CH(NCH), .RUN_LIMIT(LIM)) u_dut (
    .clk(clk), .rst(rst), .ampSel(ampSel), .chanEn(chanEn),
    .loopback(loopback), .forcing(forcing), .sigDetect(sigDetect),
    .transition(transition), .faultN(faultN)
  );

  // Inputs change at the falling edge; outputs are sampled 1 time unit after the rising edge
  task automatic stepBits(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      #1;
      @(negedge clk);
    end
  endtask

  task automatic chk(input string req, input logic [NCH-1:0] exp);
    checks++;
    if (faultN !== exp) begin
      fails++;
      $display("FAIL %s: faultN=%b expected=%b", req, faultN, exp);
    end
  endtask

  function automatic logic [NCH-1:0] allBut(input int ch);
    logic [NCH-1:0] v = '1;
    v[ch] = 1'b0;
    return v;
  endfunction

  task automatic testReset();
    @(negedge clk);
    rst = 1'b1;
    stepBits(3);
    chk("R9 reset asserts all faults", '0);
    rst = 1'b0;
    stepBits(1);
    chk("R2 all lanes good after reset", '1);
  endtask

  task automatic testRun(input int ch);
    transition = '1;
    stepBits(1);
    transition[ch] = 1'b0;
    stepBits(LIM);
    chk("R3 60 idle bits still good, R1 isolation", '1);
    stepBits(1);
    chk("R3 61 idle bits faults", allBut(ch));
    stepBits(100);
    chk("R4 saturated idle run holds fault", allBut(ch));
    transition[ch] = 1'b1;
    stepBits(1);
    chk("R4 first transition clears fault", '1);
  endtask

  task automatic testMasks(input int ch);
    transition = '1;
    ampSel = 2'b01;
    sigDetect[ch] = 1'b0;
    stepBits(1);
    chk("R5 code 01 signal loss faults", allBut(ch));
    ampSel = 2'b00;
    stepBits(1);
    chk("R5 code 00 ignores signal loss", '1);
    ampSel = 2'b11;
    stepBits(1);
    chk("R5 code 11 signal loss faults", allBut(ch));
    loopback[ch] = 1'b1;
    stepBits(1);
    chk("R6 loopback ignores signal loss", '1);
    forcing[ch] = 1'b1;
    stepBits(1);
    chk("R8 forcing faults in loopback", allBut(ch));
    forcing[ch] = 1'b0;
    transition[ch] = 1'b0;
    stepBits(LIM + 1);
    chk("R6 idle run faults in loopback", allBut(ch));
    transition[ch] = 1'b1;
    loopback[ch] = 1'b0;
    sigDetect[ch] = 1'b1;
    ampSel = 2'b01;
    stepBits(1);
    chk("R6 restored normal mode good", '1);
  endtask

  task automatic testDisable(input int ch);
    transition = '1;
    chanEn[ch] = 1'b0;
    stepBits(1);
    chk("R7 disabled lane faults", allBut(ch));
    chanEn[ch] = 1'b1;
    stepBits(1);
    transition[ch] = 1'b0;
    stepBits(50);
    chanEn[ch] = 1'b0;
    stepBits(1);
    chanEn[ch] = 1'b1;
    stepBits(20);
    chk("R7 disable restarts idle count", '1);
    transition[ch] = 1'b1;
    stepBits(1);
  endtask

  task automatic testForce(input int ch);
    transition = '1;
    forcing[ch] = 1'b1;
    stepBits(1);
    chk("R8 forcing faults", allBut(ch));
    forcing[ch] = 1'b0;
    stepBits(1);
    chk("R8 released forcing good", '1);
  endtask

  initial begin
    @(negedge clk);
    testReset();
    for (int ch = 0; ch < NCH; ch++) begin
      testRun(ch);
      testMasks(ch);
      testDisable(ch);
      testForce(ch);
    end
    testReset();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule